// File: doc/BRIEF.md
# Two-Parallel Fast FIR Filter

This block is a finite impulse response filter that takes two input samples on every clock, the even-indexed sample x(2n) and the odd-indexed sample x(2n+1), and returns the matching outputs y(2n) and y(2n+1) on every clock. Each clock therefore carries two samples, so the block's clock runs at half the sample rate. The block does not use four half-length filters for this. It uses three subfilters of ceil(N/2) taps each. The first holds the even-indexed coefficients. The second holds the odd-indexed coefficients. The third holds the sums of adjacent coefficient pairs and is fed with the sum of the two input samples. A post-add stage recombines the three results, and one subfilter result passes through a one-cycle delay on the way. The filter uses about 3N/4 multiplications per sample.

Coefficients enter serially through one port, lowest index first, before processing starts. As they stream in, the loader sorts them into the even and odd chains. It also forms each pair sum in hardware, so no separate input is needed for the third subfilter. All values are two's complement fractions. Inputs have one integer bit and FRAC_IN fractional bits. Coefficients have one integer bit and FRAC_COEF fractional bits. Outputs have one integer bit and FRAC_OUT fractional bits. Every product is rounded to FRAC_OUT fractional bits. All accumulation is modular at the output width, which is exact whenever the true output lies within the output range.

Top module: `fir2_fast_top`

## Requirements
- R1: While `rst_dp` is high at a clock edge, both outputs become zero after that edge. While `rst_coef` is high at a clock edge, `load_done` becomes low after that edge.
- R2: `load_done` is high exactly when TAPS coefficients have been accepted since the last coefficient reset. Once high, it stays high until `rst_coef` is asserted.
- R3: A coefficient is accepted at a clock edge only when `run_mode`=0, `load_start`=1 and fewer than TAPS coefficients are held. A value on `coef_in` at any other edge has no effect on the filter output.
- R4: Each pair sum h(2i)+h(2i+1) is held with two integer bits, so a pair summing to more than 1 is represented exactly.
- R5: The pre-added input x(2n)+x(2n+1) is held with two integer bits, so two large samples of the same sign do not overflow.
- R6: Each product is rounded to FRAC_OUT fractional bits. Rounding drops the lower bits by an arithmetic shift, then adds the highest dropped bit. Sums wrap modulo 2^(FRAC_OUT+1).
- R7: `dout_a` = H0·x(2n) + H1·x(2n-1), where H1·x(2n-1) is the odd subfilter result from the previous processing cycle.
- R8: `dout_b` = (H0+H1)·(x(2n)+x(2n+1)) − H0·x(2n) − H1·x(2n+1), computed within the same cycle.
- R9: The datapath advances only on edges where `run_mode`=1 and `load_done`=1. The outputs then appear one clock after the inputs. On all other edges both outputs hold their values.
- R10: `rst_dp` clears the sample history and the delayed subfilter result but keeps the coefficients. `rst_coef` clears the coefficients but leaves the sample history in place.
- R11: When TAPS is odd, the missing coefficient h(TAPS) is treated as zero. Its pair sum is therefore the last even coefficient alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one edge per sample pair |
| rst_dp | input | 1 | Synchronous datapath reset, active high |
| rst_coef | input | 1 | Synchronous coefficient reset, active high |
| run_mode | input | 1 | 0 = coefficient loading, 1 = filtering |
| load_start | input | 1 | Accepts `coef_in` this cycle while loading |
| coef_in | input | FRAC_COEF+1 | Serial coefficient, 1.FRAC_COEF, lowest index first |
| load_done | output | 1 | All TAPS coefficients are held |
| din_a | input | FRAC_IN+1 | Even sample x(2n), 1.FRAC_IN |
| din_b | input | FRAC_IN+1 | Odd sample x(2n+1), 1.FRAC_IN |
| dout_a | output | FRAC_OUT+1 | Even output y(2n), 1.FRAC_OUT |
| dout_b | output | FRAC_OUT+1 | Odd output y(2n+1), 1.FRAC_OUT |

## Verification
The bench builds the filter with TAPS=7, FRAC_IN=8, FRAC_OUT=8 and FRAC_COEF=7. An odd tap count exercises the zero-padded last odd coefficient and the lone final pair sum. A 7-bit coefficient fraction against an 8-bit output fraction leaves seven dropped bits in every product, so the rounding bit is active in most cycles. The coefficient set includes a pair summing above one, and the stimulus includes full-scale sample pairs. Together these reach the widened pair-sum and pre-add paths. A reload with a second coefficient set after `rst_coef` shows that none of the old coefficients survive.

// File: rtl/fir2_pkg.sv
package fir2_pkg;

    typedef enum logic [1:0] {
        FILL_EMPTY,
        FILL_PART,
        FILL_FULL
    } fill_e;

    function automatic int half_taps(input int n);
        return (n + 1) / 2;
    endfunction

    function automatic int count_bits(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/fir2_coef_load.sv
module fir2_coef_load
    import fir2_pkg::*;
#(
    parameter int TAPS = 8,
    parameter int CW   = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load_en,
    input  logic [CW-1:0]                 coef_in,
    output logic [half_taps(TAPS)*CW-1:0]     ev_flat,
    output logic [half_taps(TAPS)*CW-1:0]     od_flat,
    output logic [half_taps(TAPS)*(CW+1)-1:0] sm_flat,
    output fill_e                         fill
);
    localparam int HALF = half_taps(TAPS);
    localparam int CNTW = count_bits(TAPS);
    localparam int SW   = CW + 1;

    logic [CNTW-1:0]        cnt;
    logic signed [CW-1:0]   held;
    logic signed [CW-1:0]   ev [HALF];
    logic signed [CW-1:0]   od [HALF];
    logic signed [SW-1:0]   sm [HALF];

    logic                   accept, odd_idx, last_even;
    logic                   push_ev, push_od;
    logic signed [CW-1:0]   od_new;
    logic signed [SW-1:0]   sm_new;

    always_comb begin
        accept    = load_en && (cnt != CNTW'(TAPS));
        odd_idx   = cnt[0];
        last_even = (cnt == CNTW'(TAPS - 1)) && !cnt[0];
        push_ev   = accept && !odd_idx;
        push_od   = accept && (odd_idx || last_even);
        od_new    = odd_idx ? coef_in : '0;
        sm_new    = odd_idx ? ({held[CW-1], held} + {coef_in[CW-1], coef_in})
                            : {coef_in[CW-1], coef_in};
    end

    always_comb begin
        if (cnt == '0)                 fill = FILL_EMPTY;
        else if (cnt == CNTW'(TAPS))   fill = FILL_FULL;
        else                           fill = FILL_PART;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            held <= '0;
        end else if (accept) begin
            cnt <= cnt + 1'b1;
            if (!odd_idx) held <= coef_in;
        end
    end

    for (genvar i = 0; i < HALF; i++) begin : g_chain
        if (i == HALF - 1) begin : g_top
            always_ff @(posedge clk) begin
                if (rst) begin
                    ev[i] <= '0;
                    od[i] <= '0;
                    sm[i] <= '0;
                end else begin
                    if (push_ev) ev[i] <= coef_in;
                    if (push_od) begin
                        od[i] <= od_new;
                        sm[i] <= sm_new;
                    end
                end
            end
        end else begin : g_mid
            always_ff @(posedge clk) begin
                if (rst) begin
                    ev[i] <= '0;
                    od[i] <= '0;
                    sm[i] <= '0;
                end else begin
                    if (push_ev) ev[i] <= ev[i+1];
                    if (push_od) begin
                        od[i] <= od[i+1];
                        sm[i] <= sm[i+1];
                    end
                end
            end
        end
        assign ev_flat[i*CW +: CW] = ev[i];
        assign od_flat[i*CW +: CW] = od[i];
        assign sm_flat[i*SW +: SW] = sm[i];
    end

endmodule

// File: rtl/fir2_subfilt.sv
module fir2_subfilt #(
    parameter int NT    = 4,
    parameter int XW    = 9,
    parameter int CW    = 8,
    parameter int SHIFT = 7,
    parameter int OW    = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adv,
    input  logic [XW-1:0]      x_in,
    input  logic [NT*CW-1:0]   coef_flat,
    output logic [OW-1:0]      y_out
);
    localparam int PW = XW + CW;

    logic signed [XW-1:0] hist [NT-1];
    logic signed [XW-1:0] tapx [NT];
    logic [OW-1:0]        rnd  [NT];

    always_comb begin
        tapx[0] = x_in;
        for (int j = 1; j < NT; j++) tapx[j] = hist[j-1];
    end

    for (genvar j = 0; j < NT - 1; j++) begin : g_hist
        always_ff @(posedge clk) begin
            if (rst)      hist[j] <= '0;
            else if (adv) hist[j] <= tapx[j];
        end
    end

    for (genvar j = 0; j < NT; j++) begin : g_tap
        logic signed [CW-1:0] c;
        logic signed [PW-1:0] prod;
        assign c      = coef_flat[j*CW +: CW];
        assign prod   = tapx[j] * c;
        assign rnd[j] = prod[SHIFT+OW-1:SHIFT] + {{(OW-1){1'b0}}, prod[SHIFT-1]};
    end

    always_comb begin
        y_out = '0;
        for (int j = 0; j < NT; j++) y_out = y_out + rnd[j];
    end

endmodule

// File: rtl/fir2_fast_top.sv
module fir2_fast_top
    import fir2_pkg::*;
#(
    parameter int TAPS      = 8,
    parameter int FRAC_IN   = 8,
    parameter int FRAC_OUT  = 8,
    parameter int FRAC_COEF = 7
) (
    input  logic                  clk,
    input  logic                  rst_dp,
    input  logic                  rst_coef,
    input  logic                  run_mode,
    input  logic                  load_start,
    input  logic [FRAC_COEF:0]    coef_in,
    output logic                  load_done,
    input  logic [FRAC_IN:0]      din_a,
    input  logic [FRAC_IN:0]      din_b,
    output logic [FRAC_OUT:0]     dout_a,
    output logic [FRAC_OUT:0]     dout_b
);
    localparam int HALF  = half_taps(TAPS);
    localparam int XW    = FRAC_IN + 1;
    localparam int CW    = FRAC_COEF + 1;
    localparam int OW    = FRAC_OUT + 1;
    localparam int SHIFT = FRAC_IN + FRAC_COEF - FRAC_OUT;

    logic [HALF*CW-1:0]     ev_flat, od_flat;
    logic [HALF*(CW+1)-1:0] sm_flat;
    fill_e                  fill;
    logic                   adv;
    logic [XW:0]            x_sum;
    logic [OW-1:0]          y0, y1, ys, y1_dly;

    fir2_coef_load #(.TAPS(TAPS), .CW(CW)) u_load (
        .clk     (clk),
        .rst     (rst_coef),
        .load_en (!run_mode && load_start),
        .coef_in (coef_in),
        .ev_flat (ev_flat),
        .od_flat (od_flat),
        .sm_flat (sm_flat),
        .fill    (fill)
    );

    assign load_done = (fill == FILL_FULL);
    assign adv       = run_mode && load_done;
    assign x_sum     = {din_a[XW-1], din_a} + {din_b[XW-1], din_b};

    fir2_subfilt #(.NT(HALF), .XW(XW), .CW(CW), .SHIFT(SHIFT), .OW(OW)) u_even (
        .clk(clk), .rst(rst_dp), .adv(adv),
        .x_in(din_a), .coef_flat(ev_flat), .y_out(y0)
    );

    fir2_subfilt #(.NT(HALF), .XW(XW), .CW(CW), .SHIFT(SHIFT), .OW(OW)) u_odd (
        .clk(clk), .rst(rst_dp), .adv(adv),
        .x_in(din_b), .coef_flat(od_flat), .y_out(y1)
    );

    fir2_subfilt #(.NT(HALF), .XW(XW+1), .CW(CW+1), .SHIFT(SHIFT), .OW(OW)) u_sum (
        .clk(clk), .rst(rst_dp), .adv(adv),
        .x_in(x_sum), .coef_flat(sm_flat), .y_out(ys)
    );

    always_ff @(posedge clk) begin
        if (rst_dp) begin
            y1_dly <= '0;
            dout_a <= '0;
            dout_b <= '0;
        end else if (adv) begin
            y1_dly <= y1;
            dout_a <= y0 + y1_dly;
            dout_b <= ys - y0 - y1;
        end
    end

endmodule

// File: rtl/fir2_fast_chk.sv
module fir2_fast_chk #(
    parameter int OW = 9
) (
    input logic          clk,
    input logic          rst_dp,
    input logic          rst_coef,
    input logic          run_mode,
    input logic          load_start,
    input logic          load_done,
    input logic [OW-1:0] dout_a,
    input logic [OW-1:0] dout_b
);
    // R1
    out_clear_chk: assert property (@(posedge clk)
        rst_dp |=> (dout_a == '0) && (dout_b == '0));

    // R1
    coef_clear_chk: assert property (@(posedge clk)
        rst_coef |=> !load_done);

    // R2
    done_hold_chk: assert property (@(posedge clk) disable iff (rst_coef)
        load_done |=> load_done);

    // R3
    done_src_chk: assert property (@(posedge clk) disable iff (rst_coef)
        $rose(load_done) |-> $past(load_start && !run_mode));

    // R9
    freeze_chk: assert property (@(posedge clk) disable iff (rst_dp)
        !(run_mode && load_done) |=> $stable(dout_a) && $stable(dout_b));

endmodule

bind fir2_fast_top fir2_fast_chk #(.OW(FRAC_OUT + 1)) u_fir2_chk (
    .clk        (clk),
    .rst_dp     (rst_dp),
    .rst_coef   (rst_coef),
    .run_mode   (run_mode),
    .load_start (load_start),
    .load_done  (load_done),
    .dout_a     (dout_a),
    .dout_b     (dout_b)
);

// File: tb/test_fir2_fast_top.sv
module test_fir2_fast_top;
    localparam int TAPS = 7, FI = 8, FO = 8, FC = 7;
    localparam int HALF = (TAPS + 1) / 2;
    localparam int SH = FI + FC - FO;

    logic clk = 1'b0;
    logic rst_dp, rst_coef, run_mode, load_start, load_done;
    logic [FC:0] coef_in;
    logic [FI:0] din_a, din_b;
    logic [FO:0] dout_a, dout_b;

    int n_chk = 0, n_fail = 0;
    int m_h [2*HALF];
    int m_cnt = 0;
    int hxa [HALF], hxb [HALF], hxs [HALF];
    int y1p = 0, ea = 0, eb = 0;
    int seed = 7;

    always #10 clk = ~clk;

    fir2_fast_top #(.TAPS(TAPS), .FRAC_IN(FI), .FRAC_OUT(FO), .FRAC_COEF(FC)) i_fir2_fast_top (
        .clk(clk), .rst_dp(rst_dp), .rst_coef(rst_coef), .run_mode(run_mode),
        .load_start(load_start), .coef_in(coef_in), .load_done(load_done),
        .din_a(din_a), .din_b(din_b), .dout_a(dout_a), .dout_b(dout_b)
    );

    function automatic int wrapo(input longint v);
        longint w = v & ((64'sd1 << (FO + 1)) - 1);
        if (w >= (64'sd1 << FO)) w = w - (64'sd1 << (FO + 1));
        return int'(w);
    endfunction

    function automatic longint rndp(input longint p);
        return (p >>> SH) + ((p >>> (SH - 1)) & 1);
    endfunction

    function automatic int nxt();
        seed = seed * 1103515245 + 12345;
        return int'(((seed >> 16) & 32767) % 511) - 255;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int a, input int b, input bit rm, input bit ls,
                        input int c, input bit rd, input bit rc, input string tag);
        longint y0, y1, ys;
        bit done_pre;
        din_a = a[FI:0];
        din_b = b[FI:0];
        run_mode = rm;
        load_start = ls;
        coef_in = c[FC:0];
        rst_dp = rd;
        rst_coef = rc;
        done_pre = (m_cnt == TAPS);
        if (rd) begin
            for (int j = 0; j < HALF; j++) begin hxa[j] = 0; hxb[j] = 0; hxs[j] = 0; end
            y1p = 0; ea = 0; eb = 0;
        end else if (rm && done_pre) begin
            for (int j = HALF - 1; j > 0; j--) begin
                hxa[j] = hxa[j-1]; hxb[j] = hxb[j-1]; hxs[j] = hxs[j-1];
            end
            hxa[0] = a; hxb[0] = b; hxs[0] = a + b;
            y0 = 0; y1 = 0; ys = 0;
            for (int j = 0; j < HALF; j++) begin
                y0 += rndp(longint'(hxa[j]) * m_h[2*j]);
                y1 += rndp(longint'(hxb[j]) * m_h[2*j+1]);
                ys += rndp(longint'(hxs[j]) * (m_h[2*j] + m_h[2*j+1]));
            end
            ea = wrapo(y0 + y1p);
            eb = wrapo(ys - y0 - y1);
            y1p = wrapo(y1);
        end
        if (rc) m_cnt = 0;
        else if (!rm && ls && m_cnt < TAPS) begin m_h[m_cnt] = c; m_cnt++; end
        @(posedge clk);
        #5;
        check(tag, int'($signed(dout_a)), ea);
        check(tag, int'($signed(dout_b)), eb);
        check(tag, int'(load_done), int'(m_cnt == TAPS));
    endtask

    task automatic load_set(input int s0, input int s1, input int s2, input int s3,
                            input int s4, input int s5, input int s6);
        int cs [TAPS];
        cs = '{s0, s1, s2, s3, s4, s5, s6};
        for (int i = 0; i < TAPS; i++) begin
            // R3: junk between accepted coefficients, without load_start or in run mode
            tick(0, 0, 1'b0, 1'b0, 99, 1'b0, 1'b0, "R3");
            tick(11, 22, 1'b1, 1'b1, -99, 1'b0, 1'b0, "R3");
            // R2: load_done must rise only with the last coefficient
            tick(0, 0, 1'b0, 1'b1, cs[i], 1'b0, 1'b0, "R2");
        end
    endtask

    initial begin
        for (int j = 0; j < 2*HALF; j++) m_h[j] = 0;
        for (int j = 0; j < HALF; j++) begin hxa[j] = 0; hxb[j] = 0; hxs[j] = 0; end
        // R1: reset state
        tick(0, 0, 1'b0, 1'b0, 0, 1'b1, 1'b1, "R1");
        tick(0, 0, 1'b0, 1'b0, 0, 1'b1, 1'b1, "R1");
        // R4 / R11: pair h0+h1 = 254 exceeds 1.L; h6 has no odd partner
        load_set(127, 127, -100, 90, 64, -33, 127);
        // R3: coefficient offered after the chain is full is ignored
        tick(0, 0, 1'b0, 1'b1, -77, 1'b0, 1'b0, "R3");
        // R9: no advance while loading mode
        tick(200, -200, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R9");
        // R11 / R7 / R8: impulse on even input, then on odd input
        tick(255, 0, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R11");
        for (int i = 0; i < 5; i++) tick(0, 0, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R7");
        tick(0, 255, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R8");
        for (int i = 0; i < 5; i++) tick(0, 0, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R8");
        // R5: full-scale pairs of equal sign
        for (int i = 0; i < 3; i++) tick(255, 255, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R5");
        for (int i = 0; i < 3; i++) tick(-255, -255, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R5");
        // R6: mixed traffic with rounding in almost every product
        for (int i = 0; i < 60; i++) tick(nxt(), nxt(), 1'b1, 1'b0, 0, 1'b0, 1'b0, "R6");
        // R9: pause with moving inputs
        for (int i = 0; i < 4; i++) tick(nxt(), nxt(), 1'b0, 1'b0, 0, 1'b0, 1'b0, "R9");
        for (int i = 0; i < 10; i++) tick(nxt(), nxt(), 1'b1, 1'b0, 0, 1'b0, 1'b0, "R7");
        // R10: datapath reset clears history, coefficients survive
        tick(nxt(), nxt(), 1'b1, 1'b0, 0, 1'b1, 1'b0, "R10");
        for (int i = 0; i < 12; i++) tick(nxt(), nxt(), 1'b1, 1'b0, 0, 1'b0, 1'b0, "R10");
        // R10 / R9: coefficient reset stops the datapath
        tick(nxt(), nxt(), 1'b1, 1'b0, 0, 1'b0, 1'b1, "R10");
        for (int i = 0; i < 3; i++) tick(nxt(), nxt(), 1'b1, 1'b0, 0, 1'b0, 1'b0, "R9");
        load_set(-50, 20, 100, -127, 5, 77, -64);
        for (int i = 0; i < 40; i++) tick(nxt(), nxt(), 1'b1, 1'b0, 0, 1'b0, 1'b0, "R8");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule